// File: doc/BRIEF.md
# Hypervisor Intercept Decision Unit

This unit sits beside a processor's event path while a guest runs. Every guest event arrives as a numeric event code with a 64-bit parameter. The unit decides whether that event must leave the guest and return control to the hypervisor. The code space is split into ranged windows. Each window has its own bitmap, and the distance of the code from the window's base picks one bit of that bitmap. Any code not inside a small window falls into a 64-bit general vector, indexed from the external-interrupt code.

Two event kinds, model-specific register access and port I/O, need a finer permission lookup than one bit. When the general-vector bit for either kind is set, the unit passes the event to an external permission checker over a request/response port. It then waits for that checker's verdict. A single global enable gates the whole decision. The hypervisor side loads the bitmaps through a synchronous write port. An exit request comes out as a registered one-cycle pulse that carries the exit code and the exit info.

Top module: `icpt_decide`

## Requirements
- R1: While `icpt_en` is low, no event raises `exit_valid` and none is forwarded on `chk_req_valid`, whatever the bitmaps hold.
- R2: Codes 0x000 to 0x008 select bit (code - 0x000) of the 16-bit control-read map (write select 0). Codes 0x010 to 0x018 select bit (code - 0x010) of the 16-bit control-write map (select 1). An event exits when its selected bit is 1.
- R3: Codes 0x020 to 0x027 select bit (code - 0x020) of the 16-bit debug-read map (select 2). Codes 0x030 to 0x037 select bit (code - 0x030) of the 16-bit debug-write map (select 3).
- R4: Codes 0x040 to 0x05F select bit (code - 0x040) of the 32-bit exception map (select 4).
- R5: Codes 0x060 to 0x09F select bit (code - 0x060) of the 64-bit general vector (select 5). Codes that lie in no window, such as 0x009, 0x03A or 0x0A0, never exit.
- R6: Code 0x07C (register access) never exits directly. If general bit 28 is clear, nothing happens. If it is set, `chk_req_valid` pulses for one cycle, in the cycle after the event, with `chk_is_io`=0 and `chk_param` equal to the event parameter. An exit with code 0x07C follows one cycle after a response that has `chk_rsp_hit`=1. A response with the hit bit clear gives no exit.
- R7: Code 0x07B (port I/O) behaves like R6, but uses general bit 27 and `chk_is_io`=1.
- R8: A bitmap exit appears in the cycle after the accepted event and lasts one cycle. It has `exit_code` equal to the event code and `exit_info` equal to the event parameter unchanged. Back-to-back events each give their own exit.
- R9: When `bm_wr_en` is high, the map chosen by `bm_wr_sel` (0 to 5) takes the low bits of `bm_wr_data`. Select values 6 and 7 change no map.
- R10: Reset and `bm_clear` set every map to zero. A clear takes priority over a write in the same cycle. After reset, `exit_valid` and `chk_req_valid` are low and `ev_ready` is high.
- R11: While a forwarded event waits for its response, `ev_ready` is low and any event presented in that time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| icpt_en | input | 1 | Global intercept enable |
| bm_clear | input | 1 | Clears all bitmaps |
| bm_wr_en | input | 1 | Bitmap write strobe |
| bm_wr_sel | input | 3 | Bitmap select for the write |
| bm_wr_data | input | 64 | Bitmap write data, low bits used |
| ev_valid | input | 1 | Event present |
| ev_code | input | 12 | Event code |
| ev_param | input | 64 | Event parameter |
| ev_ready | output | 1 | Unit can accept an event |
| chk_req_valid | output | 1 | Forward request to a permission checker |
| chk_is_io | output | 1 | 1: port I/O checker, 0: register checker |
| chk_param | output | 64 | Parameter of the forwarded event |
| chk_rsp_valid | input | 1 | Checker response strobe |
| chk_rsp_hit | input | 1 | Checker requests an exit |
| exit_valid | output | 1 | One-cycle exit request |
| exit_code | output | 12 | Exit code |
| exit_info | output | 64 | Exit info |

## Verification
The hardest state to reach is the wait for a forwarded verdict. To get there, a register-access or I/O code must arrive with its general-vector bit set. That bit sits inside the same vector that drives the ordinary general-window exits, so the stimulus rewrites the vector between phases. While the unit waits, the bench offers an event whose bit is set and confirms that it has no effect. It then returns hit and miss responses and checks the exit that follows on each path.

// File: rtl/icpt_pkg.sv
package icpt_pkg;

  localparam int NMAP  = 6;
  localparam int IDX_W = 6;

  typedef enum logic [2:0] {
    WK_NONE = 3'd0,
    WK_CRR  = 3'd1,
    WK_CRW  = 3'd2,
    WK_DRR  = 3'd3,
    WK_DRW  = 3'd4,
    WK_EXC  = 3'd5,
    WK_GEN  = 3'd6
  } win_kind_e;

  typedef struct packed {
    win_kind_e        kind;
    logic [IDX_W-1:0] idx;
    logic             fwd;
    logic             fwd_io;
  } win_sel_t;

  function automatic int map_width(input int i);
    case (i)
      0, 1, 2, 3: map_width = 16;
      4:          map_width = 32;
      default:    map_width = 64;
    endcase
  endfunction

endpackage

// File: rtl/icpt_window_decode.sv
module icpt_window_decode
  import icpt_pkg::*;
#(
  parameter int CODE_W   = 12,
  parameter int CRR_BASE = 'h000,
  parameter int CRW_BASE = 'h010,
  parameter int DRR_BASE = 'h020,
  parameter int DRW_BASE = 'h030,
  parameter int EXC_BASE = 'h040,
  parameter int GEN_BASE = 'h060,
  parameter int MSR_CODE = 'h07C,
  parameter int IO_CODE  = 'h07B
) (
  input  logic [CODE_W-1:0] code_i,
  output win_sel_t          sel_o
);

  localparam int CR_SPAN  = 9;
  localparam int DR_SPAN  = 8;
  localparam int EXC_SPAN = 32;
  localparam int GEN_SPAN = 64;

  function automatic logic in_win(input logic [CODE_W-1:0] c,
                                  input int base, input int span);
    logic [CODE_W-1:0] off;
    off = c - CODE_W'(base);
    return (c >= CODE_W'(base)) && (off < CODE_W'(span));
  endfunction

  function automatic logic [IDX_W-1:0] offs(input logic [CODE_W-1:0] c,
                                            input int base);
    logic [CODE_W-1:0] off;
    off = c - CODE_W'(base);
    return off[IDX_W-1:0];
  endfunction

  always_comb begin
    sel_o        = '0;
    sel_o.kind   = WK_NONE;
    if (in_win(code_i, CRR_BASE, CR_SPAN)) begin
      sel_o.kind = WK_CRR;
      sel_o.idx  = offs(code_i, CRR_BASE);
    end else if (in_win(code_i, CRW_BASE, CR_SPAN)) begin
      sel_o.kind = WK_CRW;
      sel_o.idx  = offs(code_i, CRW_BASE);
    end else if (in_win(code_i, DRR_BASE, DR_SPAN)) begin
      sel_o.kind = WK_DRR;
      sel_o.idx  = offs(code_i, DRR_BASE);
    end else if (in_win(code_i, DRW_BASE, DR_SPAN)) begin
      sel_o.kind = WK_DRW;
      sel_o.idx  = offs(code_i, DRW_BASE);
    end else if (in_win(code_i, EXC_BASE, EXC_SPAN)) begin
      sel_o.kind = WK_EXC;
      sel_o.idx  = offs(code_i, EXC_BASE);
    end else if (in_win(code_i, GEN_BASE, GEN_SPAN)) begin
      sel_o.kind   = WK_GEN;
      sel_o.idx    = offs(code_i, GEN_BASE);
      sel_o.fwd    = (code_i == CODE_W'(MSR_CODE)) || (code_i == CODE_W'(IO_CODE));
      sel_o.fwd_io = (code_i == CODE_W'(IO_CODE));
    end
  end

endmodule

// File: rtl/icpt_bitmaps.sv
module icpt_bitmaps
  import icpt_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clr_i,
  input  logic                        wr_en_i,
  input  logic [2:0]                  wr_sel_i,
  input  logic [DATA_W-1:0]           wr_data_i,
  output logic [NMAP-1:0][DATA_W-1:0] maps_o
);

  for (genvar i = 0; i < NMAP; i++) begin : g_map
    localparam int W = map_width(i);
    logic [W-1:0] bits_q;

    always_ff @(posedge clk) begin
      if (rst || clr_i) begin
        bits_q <= '0;
      end else if (wr_en_i && (wr_sel_i == 3'(i))) begin
        bits_q <= wr_data_i[W-1:0];
      end
    end

    assign maps_o[i] = DATA_W'(bits_q);
  end

  a_r10_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (maps_o == '0));

  a_r9_bad_sel_no_effect: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && (!wr_en_i || wr_sel_i >= 3'(NMAP))) |=> $stable(maps_o));

endmodule

// File: rtl/icpt_fwd_ctrl.sv
module icpt_fwd_ctrl #(
  parameter int PARAM_W = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_i,
  input  logic               start_i,
  input  logic               start_io_i,
  input  logic [PARAM_W-1:0] start_param_i,
  input  logic               rsp_valid_i,
  input  logic               rsp_hit_i,
  output logic               busy_o,
  output logic               req_valid_o,
  output logic               req_io_o,
  output logic [PARAM_W-1:0] req_param_o,
  output logic               done_hit_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o      <= 1'b0;
      req_valid_o <= 1'b0;
      req_io_o    <= 1'b0;
      req_param_o <= '0;
    end else begin
      req_valid_o <= start_i && !busy_o;
      if (start_i && !busy_o) begin
        busy_o      <= 1'b1;
        req_io_o    <= start_io_i;
        req_param_o <= start_param_i;
      end else if (busy_o && rsp_valid_i) begin
        busy_o <= 1'b0;
      end
    end
  end

  assign done_hit_o = busy_o && rsp_valid_i && rsp_hit_i && en_i;

  a_r6_req_one_pulse: assert property (@(posedge clk) disable iff (rst)
    req_valid_o |=> !req_valid_o);

  a_r11_busy_with_req: assert property (@(posedge clk) disable iff (rst)
    req_valid_o |-> busy_o);

  a_r11_hold_param: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(req_param_o));

endmodule

// File: rtl/icpt_decide.sv
module icpt_decide
  import icpt_pkg::*;
#(
  parameter int CODE_W   = 12,
  parameter int PARAM_W  = 64,
  parameter int CRR_BASE = 'h000,
  parameter int CRW_BASE = 'h010,
  parameter int DRR_BASE = 'h020,
  parameter int DRW_BASE = 'h030,
  parameter int EXC_BASE = 'h040,
  parameter int GEN_BASE = 'h060,
  parameter int MSR_CODE = 'h07C,
  parameter int IO_CODE  = 'h07B
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               icpt_en,
  input  logic               bm_clear,
  input  logic               bm_wr_en,
  input  logic [2:0]         bm_wr_sel,
  input  logic [63:0]        bm_wr_data,
  input  logic               ev_valid,
  input  logic [CODE_W-1:0]  ev_code,
  input  logic [PARAM_W-1:0] ev_param,
  output logic               ev_ready,
  output logic               chk_req_valid,
  output logic               chk_is_io,
  output logic [PARAM_W-1:0] chk_param,
  input  logic               chk_rsp_valid,
  input  logic               chk_rsp_hit,
  output logic               exit_valid,
  output logic [CODE_W-1:0]  exit_code,
  output logic [PARAM_W-1:0] exit_info
);

  localparam int MAP_DW = 64;

  logic [NMAP-1:0][MAP_DW-1:0] maps;
  win_sel_t                    sel;
  logic                        sel_bit;
  logic                        accept;
  logic                        direct_hit;
  logic                        fwd_start;
  logic                        busy;
  logic                        done_hit;

  icpt_bitmaps #(.DATA_W(MAP_DW)) u_maps (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (bm_clear),
    .wr_en_i   (bm_wr_en),
    .wr_sel_i  (bm_wr_sel),
    .wr_data_i (bm_wr_data),
    .maps_o    (maps)
  );

  icpt_window_decode #(
    .CODE_W(CODE_W), .CRR_BASE(CRR_BASE), .CRW_BASE(CRW_BASE),
    .DRR_BASE(DRR_BASE), .DRW_BASE(DRW_BASE), .EXC_BASE(EXC_BASE),
    .GEN_BASE(GEN_BASE), .MSR_CODE(MSR_CODE), .IO_CODE(IO_CODE)
  ) u_dec (
    .code_i (ev_code),
    .sel_o  (sel)
  );

  always_comb begin
    case (sel.kind)
      WK_CRR:  sel_bit = maps[0][sel.idx];
      WK_CRW:  sel_bit = maps[1][sel.idx];
      WK_DRR:  sel_bit = maps[2][sel.idx];
      WK_DRW:  sel_bit = maps[3][sel.idx];
      WK_EXC:  sel_bit = maps[4][sel.idx];
      WK_GEN:  sel_bit = maps[5][sel.idx];
      default: sel_bit = 1'b0;
    endcase
  end

  assign ev_ready   = !busy;
  assign accept     = ev_valid && ev_ready && icpt_en;
  assign direct_hit = accept && sel_bit && !sel.fwd;
  assign fwd_start  = accept && sel_bit && sel.fwd;

  icpt_fwd_ctrl #(.PARAM_W(PARAM_W)) u_fwd (
    .clk           (clk),
    .rst           (rst),
    .en_i          (icpt_en),
    .start_i       (fwd_start),
    .start_io_i    (sel.fwd_io),
    .start_param_i (ev_param),
    .rsp_valid_i   (chk_rsp_valid),
    .rsp_hit_i     (chk_rsp_hit),
    .busy_o        (busy),
    .req_valid_o   (chk_req_valid),
    .req_io_o      (chk_is_io),
    .req_param_o   (chk_param),
    .done_hit_o    (done_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      exit_valid <= 1'b0;
      exit_code  <= '0;
      exit_info  <= '0;
    end else begin
      exit_valid <= direct_hit || done_hit;
      if (done_hit) begin
        exit_code <= chk_is_io ? CODE_W'(IO_CODE) : CODE_W'(MSR_CODE);
        exit_info <= chk_param;
      end else if (direct_hit) begin
        exit_code <= ev_code;
        exit_info <= ev_param;
      end
    end
  end

  a_r1_off_no_exit: assert property (@(posedge clk) disable iff (rst)
    !icpt_en |=> !exit_valid);

  a_r1_off_no_forward: assert property (@(posedge clk) disable iff (rst)
    !icpt_en |=> !chk_req_valid);

  a_r8_exit_has_cause: assert property (@(posedge clk) disable iff (rst)
    exit_valid |-> ($past(ev_valid && ev_ready) || $past(chk_rsp_valid && !ev_ready)));

  a_r8_info_is_param: assert property (@(posedge clk) disable iff (rst)
    (exit_valid && $past(ev_valid && ev_ready)) |->
      (exit_info == $past(ev_param) && exit_code == $past(ev_code)));

  a_r11_no_accept_busy: assert property (@(posedge clk) disable iff (rst)
    (!ev_ready && !chk_rsp_valid) |=> !exit_valid);

endmodule

// File: tb/icpt_decide_tb.sv
module icpt_decide_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        icpt_en = 1'b0;
  logic        bm_clear = 1'b0;
  logic        bm_wr_en = 1'b0;
  logic [2:0]  bm_wr_sel = '0;
  logic [63:0] bm_wr_data = '0;
  logic        ev_valid = 1'b0;
  logic [11:0] ev_code = '0;
  logic [63:0] ev_param = '0;
  logic        ev_ready;
  logic        chk_req_valid;
  logic        chk_is_io;
  logic [63:0] chk_param;
  logic        chk_rsp_valid = 1'b0;
  logic        chk_rsp_hit = 1'b0;
  logic        exit_valid;
  logic [11:0] exit_code;
  logic [63:0] exit_info;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  icpt_decide dut_i (
    .clk(clk), .rst(rst), .icpt_en(icpt_en), .bm_clear(bm_clear),
    .bm_wr_en(bm_wr_en), .bm_wr_sel(bm_wr_sel), .bm_wr_data(bm_wr_data),
    .ev_valid(ev_valid), .ev_code(ev_code), .ev_param(ev_param),
    .ev_ready(ev_ready), .chk_req_valid(chk_req_valid), .chk_is_io(chk_is_io),
    .chk_param(chk_param), .chk_rsp_valid(chk_rsp_valid),
    .chk_rsp_hit(chk_rsp_hit), .exit_valid(exit_valid),
    .exit_code(exit_code), .exit_info(exit_info)
  );

  // {code, expected exit}
  localparam logic [12:0] VEC [23] = '{
    {12'h000, 1'b1}, {12'h001, 1'b0}, {12'h002, 1'b1}, {12'h008, 1'b1},
    {12'h009, 1'b0}, {12'h010, 1'b0}, {12'h011, 1'b1}, {12'h018, 1'b0},
    {12'h027, 1'b1}, {12'h020, 1'b0}, {12'h030, 1'b1}, {12'h037, 1'b0},
    {12'h040, 1'b1}, {12'h05F, 1'b1}, {12'h050, 1'b0}, {12'h060, 1'b1},
    {12'h061, 1'b1}, {12'h062, 1'b0}, {12'h09F, 1'b1}, {12'h0A0, 1'b0},
    {12'h03A, 1'b0}, {12'h07C, 1'b0}, {12'h07B, 1'b0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_map(input logic [2:0] s, input logic [63:0] d);
    @(negedge clk);
    bm_wr_en = 1'b1; bm_wr_sel = s; bm_wr_data = d;
    @(negedge clk);
    bm_wr_en = 1'b0;
  endtask

  task automatic send(input logic [11:0] c, input logic [63:0] p);
    @(negedge clk);
    ev_valid = 1'b1; ev_code = c; ev_param = p;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic respond(input logic hit);
    @(negedge clk);
    chk_rsp_valid = 1'b1; chk_rsp_hit = hit;
    @(negedge clk);
    chk_rsp_valid = 1'b0; chk_rsp_hit = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    logic [63:0] p;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 exit_valid after reset", 64'(exit_valid), 64'd0);
    chk("R10 chk_req_valid after reset", 64'(chk_req_valid), 64'd0);
    chk("R10 ev_ready after reset", 64'(ev_ready), 64'd1);
    icpt_en = 1'b1;
    send(12'h000, 64'h1);
    chk("R10 maps zero after reset", 64'(exit_valid), 64'd0);

    // load maps
    wr_map(3'd0, 64'h0105);
    wr_map(3'd1, 64'h0002);
    wr_map(3'd2, 64'h0080);
    wr_map(3'd3, 64'h0001);
    wr_map(3'd4, 64'h8000_0001);
    wr_map(3'd5, 64'h8000_0000_0000_0003);

    // table walk: R2 R3 R4 R5 R8, and R6/R7 with gen bits clear
    foreach (VEC[i]) begin
      p = {32'hC0DE_0000, 20'h0, VEC[i][12:1]};
      send(VEC[i][12:1], p);
      chk($sformatf("R2-window code %h exit", VEC[i][12:1]), 64'(exit_valid), 64'(VEC[i][0]));
      chk("R6 no forward without gen bit", 64'(chk_req_valid), 64'd0);
      if (VEC[i][0]) begin
        chk("R8 exit_code", 64'(exit_code), 64'(VEC[i][12:1]));
        chk("R8 exit_info", exit_info, p);
      end
    end

    // R8 one-cycle pulse and back-to-back events
    @(negedge clk);
    ev_valid = 1'b1; ev_code = 12'h000; ev_param = 64'hAA;
    @(negedge clk);
    ev_code = 12'h002; ev_param = 64'hBB;
    chk("R8 first exit", 64'(exit_valid), 64'd1);
    chk("R8 first code", 64'(exit_code), 64'h000);
    @(negedge clk);
    ev_valid = 1'b0;
    chk("R8 second exit", 64'(exit_valid), 64'd1);
    chk("R8 second info", exit_info, 64'hBB);
    @(negedge clk);
    chk("R8 pulse ends", 64'(exit_valid), 64'd0);

    // R6 register access forward
    wr_map(3'd5, 64'h8000_0000_1800_0003);
    send(12'h07C, 64'h1234_5678_9ABC_DEF0);
    chk("R6 req valid", 64'(chk_req_valid), 64'd1);
    chk("R6 req kind", 64'(chk_is_io), 64'd0);
    chk("R6 req param", chk_param, 64'h1234_5678_9ABC_DEF0);
    chk("R6 no direct exit", 64'(exit_valid), 64'd0);
    chk("R11 not ready", 64'(ev_ready), 64'd0);
    send(12'h000, 64'h77);
    chk("R11 event ignored while waiting", 64'(exit_valid), 64'd0);
    chk("R6 request is one pulse", 64'(chk_req_valid), 64'd0);
    respond(1'b1);
    chk("R6 exit after hit", 64'(exit_valid), 64'd1);
    chk("R6 exit code", 64'(exit_code), 64'h07C);
    chk("R6 exit info", exit_info, 64'h1234_5678_9ABC_DEF0);
    chk("R11 ready again", 64'(ev_ready), 64'd1);

    // R7 I/O forward, miss then hit
    send(12'h07B, 64'h0000_0000_0060_0010);
    chk("R7 req valid", 64'(chk_req_valid), 64'd1);
    chk("R7 req kind", 64'(chk_is_io), 64'd1);
    respond(1'b0);
    chk("R7 miss gives no exit", 64'(exit_valid), 64'd0);
    chk("R7 ready after miss", 64'(ev_ready), 64'd1);
    send(12'h07B, 64'h0000_0000_0070_0020);
    respond(1'b1);
    chk("R7 exit after hit", 64'(exit_valid), 64'd1);
    chk("R7 exit code", 64'(exit_code), 64'h07B);
    chk("R7 exit info", exit_info, 64'h0000_0000_0070_0020);

    // R1 enable off
    icpt_en = 1'b0;
    send(12'h000, 64'h5);
    chk("R1 no exit when disabled", 64'(exit_valid), 64'd0);
    send(12'h07C, 64'h6);
    chk("R1 no forward when disabled", 64'(chk_req_valid), 64'd0);
    send(12'h040, 64'h7);
    chk("R1 no exception exit when disabled", 64'(exit_valid), 64'd0);
    icpt_en = 1'b1;

    // R10 clear, and clear beats write
    @(negedge clk);
    bm_clear = 1'b1;
    @(negedge clk);
    bm_clear = 1'b0;
    send(12'h002, 64'h8);
    chk("R10 clear empties control map", 64'(exit_valid), 64'd0);
    @(negedge clk);
    bm_clear = 1'b1; bm_wr_en = 1'b1; bm_wr_sel = 3'd0; bm_wr_data = '1;
    @(negedge clk);
    bm_clear = 1'b0; bm_wr_en = 1'b0;
    send(12'h000, 64'h9);
    chk("R10 clear wins over write", 64'(exit_valid), 64'd0);

    // R9 unused selects change nothing
    wr_map(3'd6, '1);
    wr_map(3'd7, '1);
    send(12'h000, 64'hA);
    chk("R9 select 6/7 leaves control map", 64'(exit_valid), 64'd0);
    send(12'h040, 64'hB);
    chk("R9 select 6/7 leaves exception map", 64'(exit_valid), 64'd0);
    send(12'h060, 64'hC);
    chk("R9 select 6/7 leaves general map", 64'(exit_valid), 64'd0);
    wr_map(3'd3, 64'hFFFF_FFFF_FFFF_0080);
    send(12'h037, 64'hD);
    chk("R9 debug-write map takes low bits", 64'(exit_valid), 64'd1);
    send(12'h030, 64'hE);
    chk("R3 debug-write bit 0 clear", 64'(exit_valid), 64'd0);

    finish_run();
  end

endmodule